// File: doc/BRIEF.md
# Guarded Control Register Bank

This block holds the host-visible control and status fields of a communication controller. A host reaches it over a plain synchronous register port: a byte address, 32-bit write data, a write strobe, and read data that follows the address within the same cycle. Every writable field has a write-permission rule built from one or more permission inputs or internal states. A write is accepted when any one of those conditions is true. When none is true, the write is dropped and nothing reports it. Writes to reserved bits and unmapped addresses are ignored, and those bits and addresses read as zero.

Besides the synchronous system reset, two events restore fields. First, writing the run code to the protocol command field restores the run-sensitive configuration byte. Second, a granted buffer disable restores that buffer's configuration byte. A buffer disable is a handshake. The host writes the disable trigger while the buffer is enabled. The block then raises a one-cycle request, and the controller answers with a grant in that same cycle. A row of flags can be raised by hardware and cleared by writing one. A small filter table lives in storage that has no reset and keeps its contents across a system reset.

Top module: `ctl_guard_regbank`

Register map, using word-aligned byte addresses with address bits [1:0] ignored:

- 0x00 holds the command field in bits [3:0].
- 0x04 holds configuration byte A in bits [7:0] and configuration byte B in bits [15:8].
- 0x08 holds the flags in bits [7:0].
- 0x10 + 4n is the control word of buffer n. Bit 0 is the disable trigger, bit 1 the enable trigger, bit 2 the enabled status and bit 3 the disable request. Bits [15:8] hold the buffer's configuration byte.
- 0x20 + 4n holds filter entry n in bits [15:0].

## Requirements
- R1: After a system reset the command field reads 0, configuration A reads 0x3C and configuration B reads 0x10. The flags read 0, every buffer is disabled with configuration byte 0x00, and dis_req_o and run_o are low.
- R2: Filter entries keep their contents across a system reset.
- R3: Configuration A is written only when perm_i[0] or perm_i[1] is high. Configuration B is written only when perm_i[2] is high. Otherwise the fields keep their values.
- R4: A high bit of flag_set_i sets that flag at the next edge. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R5: If a hardware set and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R6: Reserved bits read 0, and writes to them have no effect. Addresses outside the map read 0, and writes to them change nothing.
- R7: Writing 4'b0101 to the command field restores configuration B to 0x10 on that edge and raises run_o for exactly the next cycle. Any other command value leaves configuration B unchanged and run_o low.
- R8: Writing the enable trigger (bit 1) sets a disabled buffer's enabled status. Writing the disable trigger (bit 0) to an enabled buffer raises its dis_req_o in the following cycle, and the request bit (bit 3) reads 1 in that cycle. A disable trigger sent to a disabled buffer is ignored.
- R9: grant_i is sampled only in the cycle when dis_req_o is high. If grant_i is high then, the enabled status clears and the buffer configuration byte returns to 0x00 on that edge. If grant_i is low then, the request lapses and the buffer stays enabled. A grant at any other time has no effect.
- R10: A buffer's configuration byte is written only when the buffer is disabled or perm_i[3] is high.
- R11: A filter entry is written only when its buffer is disabled or perm_i[4] is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| perm_i | input | 5 | Write-permission conditions |
| flag_set_i | input | 8 | Hardware flag set, one bit per flag |
| grant_i | input | 4 | Controller disable grant, one bit per buffer |
| dis_req_o | output | 4 | Disable request awaiting grant, one bit per buffer |
| buf_en_o | output | 4 | Buffer enabled status |
| run_o | output | 1 | One-cycle pulse after a run command |

## Verification
Read data follows the address within the same cycle, so any wrong stored field appears on rdata_o the first time its address is driven after the edge that corrupted it. The bench reads back after every write and every handshake step. A lost or spurious disable request shows on dis_req_o and buf_en_o one cycle after the trigger write. A missed field restore shows in the readback that immediately follows the run command or the grant. Because the filter table has no reset, only a readback after a second reset can expose an entry that was cleared when it should have been kept.

// File: rtl/grb_pkg.sv
package grb_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int NBUF_DEF = 4;
    localparam int FLAG_DEF = 8;
    localparam int FIL_DEF  = 16;
    localparam int CMD_W    = 4;

    localparam int BUF_WORD = 4;
    localparam int FIL_WORD = 8;

    localparam logic [CMD_W-1:0] CMD_RUN  = 4'b0101;
    localparam logic [7:0]       CFGA_RST = 8'h3C;
    localparam logic [7:0]       CFGB_RST = 8'h10;
    localparam logic [7:0]       BCFG_RST = 8'h00;

    localparam int BIT_DIS  = 0;
    localparam int BIT_ENA  = 1;
    localparam int BIT_ST   = 2;
    localparam int BIT_PEND = 3;

    typedef enum logic [2:0] {
        RG_CMD, RG_CFG, RG_FLAG, RG_BUF, RG_FIL, RG_NONE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [7:0] idx;
    } decode_t;

    function automatic decode_t grb_decode(input logic [ADDR_W-1:0] a, input int nbuf);
        decode_t d;
        int      wi;
        wi    = int'(a[ADDR_W-1:2]);
        d.sel = RG_NONE;
        d.idx = '0;
        if (wi == 0)      d.sel = RG_CMD;
        else if (wi == 1) d.sel = RG_CFG;
        else if (wi == 2) d.sel = RG_FLAG;
        else if (wi >= BUF_WORD && wi < BUF_WORD + nbuf) begin
            d.sel = RG_BUF;
            d.idx = 8'(wi - BUF_WORD);
        end else if (wi >= FIL_WORD && wi < FIL_WORD + nbuf) begin
            d.sel = RG_FIL;
            d.idx = 8'(wi - FIL_WORD);
        end
        return d;
    endfunction
endpackage

// File: rtl/grb_flag_bank.sv
module grb_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;

    // R5: a hardware set is never lost, even under a same-cycle clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));

    // R4: a flag rises only when hardware asked for it
    a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/grb_buf_ctrl.sv
module grb_buf_ctrl import grb_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_i,
    input  logic       dis_trig_i,
    input  logic       ena_trig_i,
    input  logic [7:0] cfg_wdata_i,
    input  logic       perm_i,
    input  logic       grant_i,
    output logic       en_o,
    output logic       pend_o,
    output logic [7:0] cfg_o
);
    logic       en_q;
    logic       pend_q;
    logic [7:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
            cfg_q  <= BCFG_RST;
        end else begin
            pend_q <= 1'b0;
            if (wr_i) begin
                if (dis_trig_i && en_q)  pend_q <= 1'b1;
                if (ena_trig_i && !en_q) en_q   <= 1'b1;
                if (!en_q || perm_i)     cfg_q  <= cfg_wdata_i;
            end
            // granted disable: overrides any same-cycle host write
            if (pend_q && grant_i) begin
                en_q   <= 1'b0;
                pend_q <= 1'b0;
                cfg_q  <= BCFG_RST;
            end
        end
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;
    assign cfg_o  = cfg_q;

    // R8: a request only exists for a buffer that was enabled
    a_r8_req_needs_enable: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> $past(en_q));

    // R9: the status only falls on a granted request
    a_r9_fall_needs_grant: assert property (@(posedge clk) disable iff (rst)
        $fell(en_q) |-> $past(pend_q && grant_i));

    // R9: the configuration byte is restored on the disabling edge
    a_r9_cfg_restored: assert property (@(posedge clk) disable iff (rst)
        $fell(en_q) |-> (cfg_q == BCFG_RST));
endmodule

// File: rtl/grb_filter_mem.sv
module grb_filter_mem #(
    parameter int DEPTH = 4,
    parameter int W     = 16,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [W-1:0]     wdata_i,
    input  logic [IDX_W-1:0] ridx_i,
    output logic [W-1:0]     rdata_o
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[widx_i] <= wdata_i;
    end

    assign rdata_o = mem[ridx_i];
endmodule

// File: rtl/ctl_guard_regbank.sv
module ctl_guard_regbank import grb_pkg::*; #(
    parameter int NBUF   = NBUF_DEF,
    parameter int FLAG_W = FLAG_DEF,
    parameter int FIL_W  = FIL_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [4:0]        perm_i,
    input  logic [FLAG_W-1:0] flag_set_i,
    input  logic [NBUF-1:0]   grant_i,
    output logic [NBUF-1:0]   dis_req_o,
    output logic [NBUF-1:0]   buf_en_o,
    output logic              run_o
);
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1;

    decode_t          dec;
    logic [IDX_W-1:0] bidx;
    logic             wr_cmd, wr_cfg, wr_flag, wr_fil;
    logic [NBUF-1:0]  wr_buf;

    assign dec     = grb_decode(addr_i, NBUF);
    assign bidx    = dec.idx[IDX_W-1:0];
    assign wr_cmd  = we_i && (dec.sel == RG_CMD);
    assign wr_cfg  = we_i && (dec.sel == RG_CFG);
    assign wr_flag = we_i && (dec.sel == RG_FLAG);
    assign wr_fil  = we_i && (dec.sel == RG_FIL);

    // command and configuration fields
    logic [CMD_W-1:0] cmd_q;
    logic [7:0]       cfga_q, cfgb_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            cfga_q <= CFGA_RST;
            cfgb_q <= CFGB_RST;
            run_q  <= 1'b0;
        end else begin
            run_q <= 1'b0;
            if (wr_cfg && (perm_i[0] || perm_i[1])) cfga_q <= wdata_i[7:0];
            if (wr_cfg && perm_i[2])                cfgb_q <= wdata_i[15:8];
            if (wr_cmd) begin
                cmd_q <= wdata_i[CMD_W-1:0];
                if (wdata_i[CMD_W-1:0] == CMD_RUN) begin
                    run_q  <= 1'b1;
                    cfgb_q <= CFGB_RST;
                end
            end
        end
    end

    assign run_o = run_q;

    // write-one-to-clear flags
    logic [FLAG_W-1:0] flags;
    logic [FLAG_W-1:0] flag_clr;

    assign flag_clr = wr_flag ? wdata_i[FLAG_W-1:0] : '0;

    grb_flag_bank #(.W(FLAG_W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (flag_set_i),
        .clr_i   (flag_clr),
        .flags_o (flags)
    );

    // per-buffer enable/disable handshake
    logic [NBUF-1:0][7:0] bcfg;
    logic [NBUF-1:0]      bpend;

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        assign wr_buf[b] = we_i && (dec.sel == RG_BUF) && (bidx == IDX_W'(b));

        grb_buf_ctrl u_buf (
            .clk         (clk),
            .rst         (rst),
            .wr_i        (wr_buf[b]),
            .dis_trig_i  (wdata_i[BIT_DIS]),
            .ena_trig_i  (wdata_i[BIT_ENA]),
            .cfg_wdata_i (wdata_i[15:8]),
            .perm_i      (perm_i[3]),
            .grant_i     (grant_i[b]),
            .en_o        (buf_en_o[b]),
            .pend_o      (bpend[b]),
            .cfg_o       (bcfg[b])
        );
    end

    assign dis_req_o = bpend;

    // filter table, no reset
    logic [FIL_W-1:0] fil_rdata;
    logic             fil_we;

    assign fil_we = wr_fil && (!buf_en_o[bidx] || perm_i[4]);

    grb_filter_mem #(.DEPTH(NBUF), .W(FIL_W), .IDX_W(IDX_W)) u_fil (
        .clk     (clk),
        .we_i    (fil_we),
        .widx_i  (bidx),
        .wdata_i (wdata_i[FIL_W-1:0]),
        .ridx_i  (bidx),
        .rdata_o (fil_rdata)
    );

    // readback
    always_comb begin
        rdata_o = '0;
        case (dec.sel)
            RG_CMD:  rdata_o[CMD_W-1:0]  = cmd_q;
            RG_CFG:  rdata_o[15:0]       = {cfgb_q, cfga_q};
            RG_FLAG: rdata_o[FLAG_W-1:0] = flags;
            RG_BUF: begin
                rdata_o[15:8]     = bcfg[bidx];
                rdata_o[BIT_ST]   = buf_en_o[bidx];
                rdata_o[BIT_PEND] = bpend[bidx];
            end
            RG_FIL:  rdata_o[FIL_W-1:0]  = fil_rdata;
            default: rdata_o = '0;
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{wdata_i[DATA_W-1:16], dec.idx};

    // R3: a refused configuration write leaves field A untouched
    a_r3_locked_cfga: assert property (@(posedge clk) disable iff (rst)
        (wr_cfg && !(perm_i[0] || perm_i[1])) |=> $stable(cfga_q));

    // R3: a refused configuration write leaves field B untouched
    a_r3_locked_cfgb: assert property (@(posedge clk) disable iff (rst)
        (wr_cfg && !perm_i[2]) |=> $stable(cfgb_q));

    // R7: while the run pulse is high, field B shows its restored value
    a_r7_run_restores: assert property (@(posedge clk) disable iff (rst)
        run_o |-> (cfgb_q == CFGB_RST));

    // R7: the run pulse lasts one cycle
    a_r7_run_single: assert property (@(posedge clk) disable iff (rst)
        run_o |=> !run_o);
endmodule

// File: tb/ctl_guard_regbank_test.sv
`timescale 1ns/1ps
module ctl_guard_regbank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic [4:0]  perm = '0;
    logic [7:0]  fset = '0;
    logic [3:0]  grant = '0;
    logic [3:0]  dis_req;
    logic [3:0]  buf_en;
    logic        run;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ctl_guard_regbank uut (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .we_i       (we),
        .rdata_o    (rdata),
        .perm_i     (perm),
        .flag_set_i (fset),
        .grant_i    (grant),
        .dis_req_o  (dis_req),
        .buf_en_o   (buf_en),
        .run_o      (run)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        logic [7:0]  exp_a, exp_b;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // filter entries written before a second reset (R2)
        for (int i = 0; i < 4; i++) wr(8'(8'h20 + 4 * i), 32'hFFFF0000 | (32'h1111 * (i + 1)));
        do_reset();

        // R1: reset values
        rd(8'h00, v); chk("R1 cmd", v, 32'h0);
        rd(8'h04, v); chk("R1 cfg", v, 32'h0000103C);
        rd(8'h08, v); chk("R1 flags", v, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd(8'(8'h10 + 4 * i), v); chk("R1 buffer word", v, 32'h0);
        end
        chk("R1 outputs", {27'h0, dis_req, run}, 32'h0);
        chk("R1 buf_en", {28'h0, buf_en}, 32'h0);

        // R2: filter table kept across reset
        for (int i = 0; i < 4; i++) begin
            rd(8'(8'h20 + 4 * i), v); chk("R2 filter kept", v, 32'h1111 * (i + 1));
        end

        // R3 / R6: permission sweep on configuration bytes
        exp_a = 8'h3C; exp_b = 8'h10;
        for (int p = 0; p < 8; p++) begin
            logic [7:0] lo, hi;
            lo = 8'(p * 29 + 1); hi = 8'(p * 17 + 3);
            perm = 5'(p);
            wr(8'h04, {16'hFFFF, hi, lo});
            perm = '0;
            if (p[0] || p[1]) exp_a = lo;
            if (p[2])         exp_b = hi;
            rd(8'h04, v); chk("R3 cfg permission (R6 reserved zero)", v, {16'h0, exp_b, exp_a});
        end

        // R7: all command codes
        for (int c = 0; c < 16; c++) begin
            perm = 5'b00100;
            wr(8'h04, {16'h0, 8'h77, exp_a});
            perm = '0;
            wr(8'h00, 32'hFFFFFFF0 | 32'(c));
            chk("R7 run pulse", {31'h0, run}, (c == 5) ? 32'h1 : 32'h0);
            rd(8'h04, v); chk("R7 cfg B", v, {16'h0, (c == 5) ? 8'h10 : 8'h77, exp_a});
            rd(8'h00, v); chk("R7 cmd readback", v, 32'(c));
            @(negedge clk);
            chk("R7 pulse ends", {31'h0, run}, 32'h0);
        end
        exp_b = 8'h77;

        // R4: write-one-to-clear sweep
        for (int m = 0; m < 256; m++) begin
            @(negedge clk); fset = 8'hFF;
            @(negedge clk); fset = 8'h00;
            wr(8'h08, 32'hFFFFFF00 | 32'(m));
            rd(8'h08, v); chk("R4 w1c", v, 32'(~m & 8'hFF));
        end
        wr(8'h08, 32'hFF);
        @(negedge clk); fset = 8'hA5;
        @(negedge clk); fset = 8'h00;
        rd(8'h08, v); chk("R4 hardware set", v, 32'hA5);
        wr(8'h08, 32'h0);
        rd(8'h08, v); chk("R4 zero write keeps", v, 32'hA5);

        // R5: same-cycle set and clear
        fset = 8'h81;
        wr(8'h08, 32'hFF);
        fset = 8'h00;
        rd(8'h08, v); chk("R5 set wins", v, 32'h81);

        // R6: unmapped addresses
        for (int w = 12; w < 64; w++) begin
            wr(8'(w * 4), 32'hFFFFFFFF);
            rd(8'(w * 4), v); chk("R6 unmapped reads zero", v, 32'h0);
        end
        wr(8'h0C, 32'hFFFFFFFF);
        rd(8'h0C, v); chk("R6 gap reads zero", v, 32'h0);
        rd(8'h04, v); chk("R6 cfg untouched", v, {16'h0, exp_b, exp_a});
        rd(8'h08, v); chk("R6 flags untouched", v, 32'h81);

        // R8 / R10: buffer 1 handshake steps
        wr(8'h14, 32'h00005A00);
        rd(8'h14, v); chk("R10 cfg write while disabled", v, 32'h00005A00);
        wr(8'h14, 32'h00005A01);
        chk("R8 disable ignored when disabled", {28'h0, dis_req}, 32'h0);
        wr(8'h14, 32'h00005A02);
        rd(8'h14, v); chk("R8 enable", v, 32'h00005A04);
        chk("R8 buf_en", {28'h0, buf_en}, 32'h2);
        wr(8'h14, 32'h00003300);
        rd(8'h14, v); chk("R10 locked when enabled", v, 32'h00005A04);
        perm = 5'b01000;
        wr(8'h14, 32'h00003C00);
        perm = '0;
        rd(8'h14, v); chk("R10 perm override", v, 32'h00003C04);

        // R9: request without grant lapses
        wr(8'h14, 32'h00003C01);
        chk("R8 request raised", {28'h0, dis_req}, 32'h2);
        rd(8'h14, v); chk("R8 request bit", v, 32'h00003C0C);
        @(negedge clk);
        chk("R9 ungranted lapses", {28'h0, dis_req}, 32'h0);
        rd(8'h14, v); chk("R9 stays enabled", v, 32'h00003C04);
        grant = 4'hF;
        @(negedge clk);
        grant = 4'h0;
        rd(8'h14, v); chk("R9 stray grant ignored", v, 32'h00003C04);

        // R9: granted disable on every buffer
        for (int b = 0; b < 4; b++) begin
            logic [7:0] ba;
            ba = 8'(8'h10 + 4 * b);
            if (b != 1) begin
                wr(ba, {16'h0, 8'(b * 16 + 7), 8'h00});
                wr(ba, 32'h2);
            end
        end
        chk("R8 all enabled", {28'h0, buf_en}, 32'hF);
        for (int b = 0; b < 4; b++) begin
            logic [7:0] ba;
            ba = 8'(8'h10 + 4 * b);
            wr(ba, 32'h1);
            grant = 4'(1 << b);
            @(negedge clk);
            grant = '0;
            rd(ba, v); chk("R9 granted disable restores", v, 32'h0);
            chk("R9 other buffers", {28'h0, buf_en}, 32'(4'hF << (b + 1)) & 32'hF);
        end

        // R11: filter write permission
        wr(8'h20, 32'hFFFFBEEF);
        rd(8'h20, v); chk("R11 write while disabled", v, 32'h0000BEEF);
        wr(8'h10, 32'h2);
        wr(8'h20, 32'h00001234);
        rd(8'h20, v); chk("R11 locked when enabled", v, 32'h0000BEEF);
        perm = 5'b10000;
        wr(8'h20, 32'h00001234);
        perm = '0;
        rd(8'h20, v); chk("R11 perm override", v, 32'h00001234);

        // R2 / R1: reset again
        do_reset();
        rd(8'h20, v); chk("R2 entry 0 kept", v, 32'h00001234);
        rd(8'h2C, v); chk("R2 entry 3 kept", v, 32'h00004444);
        rd(8'h10, v); chk("R1 buffer reset", v, 32'h0);
        rd(8'h04, v); chk("R1 cfg reset", v, 32'h0000103C);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule